// File: doc/BRIEF.md
# Base Timer Interrupt Controller

This block derives four periodic ticks from one free-running counter clocked by the 4 MHz system clock. With the default parameters the ticks repeat every 1024, 2048, 4096 and 65536 cycles, which is 0.256 ms, 0.512 ms, 1.024 ms and 16.384 ms. Each tick sets its own sticky flag. Four peripheral event inputs also set sticky flags: timer, pulse counter, SPI and comparator. A flag is set by its source whether or not its enable bit is set. The enable only decides whether that flag contributes to the single interrupt request line.

Software reaches the block through a small synchronous register port. The port has a 2-bit address, a write strobe, 4-bit write data and 4-bit read data. Read data is combinational from the address. There are two enable registers and two flag registers. A flag is cleared by writing 0 to its bit, and writing 1 leaves it alone, so one write can clear a chosen subset of flags without touching the rest. The port carries no data stream, so it has no valid/ready handshake: every write completes in the cycle it is presented.

Top module: `bt_irq_ctrl`

## Requirements
- R1: Tick k pulses for one cycle each time the low TAPk bits of the free-running counter are all ones. The counter is 0 in the first cycle after reset and counts up by one per cycle, so the flag for tick k first reads 1 after 2^TAPk clock edges and is set again every 2^TAPk edges. The defaults are TAP0=10, TAP1=11, TAP2=12 and TAP3=16.
- R2: Address 0 is the tick enable register. Bit 0 enables the shortest interval and bit 3 the longest. A write stores wdata and a read returns the stored value.
- R3: Address 1 is the event enable register: bit 0 is timer, bit 1 is pulse counter, bit 2 is SPI and bit 3 is comparator. It is written and read back like address 0.
- R4: Address 2 holds the tick flags and address 3 the event flags, with the same bit order as addresses 0 and 1. A tick, or a high event input bit, sets its flag on the next edge even when the matching enable is 0.
- R5: A write to address 2 or 3 clears each flag whose wdata bit is 0 and leaves each flag whose wdata bit is 1 unchanged.
- R6: After reset, all enables and all flags read 0 and irq_o is 0.
- R7: If a flag's set source and a write-0 to that flag land on the same edge, the flag ends up set.
- R8: irq_o is high exactly when some flag and its enable are both 1. It follows register changes in the same cycle, and it stays low while both enable registers are 0.
- R9: A write changes only the register at its address. rdata_o shows the register selected by addr_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 4 | Peripheral event pulses: timer, pulse counter, SPI, comparator |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with an 8-bit counter and taps at bits 3, 4, 5 and 8. The longest tick therefore rolls over every 256 cycles, and several of its rollovers fit in a short run. These small taps also make it easy to place a write exactly on the edge where a tick fires, which is needed to exercise set-beats-clear. The exact flag pattern just before and just after the longest tap rolls over is checked as well. Partial clears and write-1 hold are exercised at phases chosen so that no tick interferes.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned ADDR_W  = 2;

  typedef logic [NUM_SRC-1:0] nib_t;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_TICK_EN   = 2'd0,
    ADDR_EVT_EN    = 2'd1,
    ADDR_TICK_FLAG = 2'd2,
    ADDR_EVT_FLAG  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TAP0  = 10,
  parameter int unsigned TAP1  = 11,
  parameter int unsigned TAP2  = 12,
  parameter int unsigned TAP3  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [bt_pkg::NUM_SRC-1:0] tick_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(1);
  end

  // Each tap fires on the last count before its low bits wrap.
  for (genvar g = 0; g < int'(bt_pkg::NUM_SRC); g++) begin : g_tap
    localparam int unsigned TB = (g == 0) ? TAP0 :
                                 (g == 1) ? TAP1 :
                                 (g == 2) ? TAP2 : TAP3;
    assign tick_o[g] = &cnt_q[TB-1:0];
  end
endmodule

// File: rtl/bt_enable_reg.sv
module bt_enable_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/bt_flag_bank.sv
module bt_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < int'(N); g++) begin : g_flag
    // A set on the same edge as a clear takes priority.
    always_ff @(posedge clk) begin
      if (!rst_n)         flag_o[g] <= 1'b0;
      else if (set_i[g])  flag_o[g] <= 1'b1;
      else if (clr_i[g])  flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/bt_irq_ctrl.sv
module bt_irq_ctrl
  import bt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TAP0  = 10,
  parameter int unsigned TAP1  = 11,
  parameter int unsigned TAP2  = 12,
  parameter int unsigned TAP3  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] evt_i,
  input  logic [1:0] addr_i,
  input  logic       wr_en_i,
  input  logic [3:0] wdata_i,
  output logic [3:0] rdata_o,
  output logic       irq_o
);
  reg_addr_e addr_e;
  nib_t      tick;
  nib_t      en_tick, en_evt;
  nib_t      flg_tick, flg_evt;
  nib_t      clr_tick, clr_evt;
  logic      we_en_tick, we_en_evt;

  assign addr_e     = reg_addr_e'(addr_i);
  assign we_en_tick = wr_en_i && (addr_e == ADDR_TICK_EN);
  assign we_en_evt  = wr_en_i && (addr_e == ADDR_EVT_EN);
  assign clr_tick   = (wr_en_i && (addr_e == ADDR_TICK_FLAG)) ? ~wdata_i : '0;
  assign clr_evt    = (wr_en_i && (addr_e == ADDR_EVT_FLAG))  ? ~wdata_i : '0;

  bt_prescaler #(
    .CNT_W(CNT_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  bt_enable_reg #(.N(NUM_SRC)) u_en_tick (
    .clk(clk), .rst_n(rst_n), .we_i(we_en_tick), .d_i(wdata_i), .q_o(en_tick)
  );

  bt_enable_reg #(.N(NUM_SRC)) u_en_evt (
    .clk(clk), .rst_n(rst_n), .we_i(we_en_evt), .d_i(wdata_i), .q_o(en_evt)
  );

  bt_flag_bank #(.N(NUM_SRC)) u_flg_tick (
    .clk(clk), .rst_n(rst_n), .set_i(tick), .clr_i(clr_tick), .flag_o(flg_tick)
  );

  bt_flag_bank #(.N(NUM_SRC)) u_flg_evt (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr_evt), .flag_o(flg_evt)
  );

  always_comb begin
    unique case (addr_e)
      ADDR_TICK_EN:   rdata_o = en_tick;
      ADDR_EVT_EN:    rdata_o = en_evt;
      ADDR_TICK_FLAG: rdata_o = flg_tick;
      default:        rdata_o = flg_evt;
    endcase
  end

  assign irq_o = |((flg_tick & en_tick) | (flg_evt & en_evt));
endmodule

// File: rtl/bt_irq_ctrl_chk.sv
module bt_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] evt_i,
  input logic [1:0] addr_i,
  input logic       wr_en_i,
  input logic [3:0] wdata_i,
  input logic       irq_o,
  input logic [3:0] tick,
  input logic [3:0] en_tick,
  input logic [3:0] en_evt,
  input logic [3:0] flg_tick,
  input logic [3:0] flg_evt
);
  // R1: longer taps only fire together with all shorter ones, for one cycle.
  assert_tick_nested_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick[3] |-> tick[2]) and (tick[2] |-> tick[1]) and (tick[1] |-> tick[0]));
  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick[0] |=> !tick[0]);

  // R2: a tick enable write is visible on the next cycle.
  assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 2'd0) |=> (en_tick == $past(wdata_i)));

  // R5: write-0 with no set source clears; write-1 keeps the old value.
  assert_clear_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 2'd2) |=>
      ((flg_tick & ~$past(wdata_i) & ~$past(tick)) == 4'd0));
  assert_keep_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == 2'd3 && evt_i == 4'd0) |=>
      ((flg_evt & $past(wdata_i)) == ($past(flg_evt) & $past(wdata_i))));

  // R7: a set source always leaves its flag high.
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|tick || |evt_i) |=>
      (((flg_tick & $past(tick)) == $past(tick)) && ((flg_evt & $past(evt_i)) == $past(evt_i))));

  // R8: no enable, no request.
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_tick == 4'd0 && en_evt == 4'd0) |-> !irq_o);
endmodule

bind bt_irq_ctrl bt_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .tick(tick), .en_tick(en_tick),
  .en_evt(en_evt), .flg_tick(flg_tick), .flg_evt(flg_evt)
);

// File: tb/bt_irq_ctrl_tb.sv
module bt_irq_ctrl_tb;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned TP0 = 3, TP1 = 4, TP2 = 5, TP3 = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt_i = '0;
  logic [1:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wdata_i = '0;
  logic [3:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bt_irq_ctrl #(.CNT_W(CNT_W), .TAP0(TP0), .TAP1(TP1), .TAP2(TP2), .TAP3(TP3)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // Reference model built from the requirements.
  int unsigned cyc;
  logic [3:0] m_en0, m_en1, m_f0, m_f1;

  function automatic logic fires(int unsigned n, int unsigned t);
    return (n % (32'd1 << t)) == ((32'd1 << t) - 1);
  endfunction

  function automatic logic [3:0] tick_vec(int unsigned n);
    return {fires(n, TP3), fires(n, TP2), fires(n, TP1), fires(n, TP0)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0; m_en0 <= '0; m_en1 <= '0; m_f0 <= '0; m_f1 <= '0;
    end else begin
      cyc <= cyc + 1;
      if (wr_en_i && addr_i == 2'd0) m_en0 <= wdata_i;
      if (wr_en_i && addr_i == 2'd1) m_en1 <= wdata_i;
      m_f0 <= tick_vec(cyc) | (m_f0 & ((wr_en_i && addr_i == 2'd2) ? wdata_i : 4'hF));
      m_f1 <= evt_i | (m_f1 & ((wr_en_i && addr_i == 2'd3) ? wdata_i : 4'hF));
    end
  end

  function automatic logic [3:0] model_rd(logic [1:0] a);
    case (a)
      2'd0: return m_en0;
      2'd1: return m_en1;
      2'd2: return m_f0;
      default: return m_f1;
    endcase
  endfunction

  // Scoreboard.
  typedef struct {
    logic [1:0] addr;
    logic [3:0] exp_d;
    logic       exp_irq;
    logic       cmp_irq;
    string      tag;
  } item_t;
  item_t sb_q[$];
  event  sample_ev;

  always @(sample_ev) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rdata_o !== it.exp_d || (it.cmp_irq && irq_o !== it.exp_irq)) begin
        errors++;
        $display("FAIL %s addr=%0d rdata=%b irq=%b expected rdata=%b irq=%b",
                 it.tag, it.addr, rdata_o, irq_o, it.exp_d, it.exp_irq);
      end
    end
  end

  task automatic chk_now(input logic [1:0] a, input string tag);
    item_t it;
    addr_i = a;
    #2;
    it.addr = a; it.exp_d = model_rd(a);
    it.exp_irq = |((m_f0 & m_en0) | (m_f1 & m_en1)); it.cmp_irq = 1'b1; it.tag = tag;
    sb_q.push_back(it);
    ->sample_ev;
    #1;
  endtask

  task automatic chk(input logic [1:0] a, input string tag);
    @(negedge clk);
    chk_now(a, tag);
  endtask

  task automatic chk_val_now(input logic [1:0] a, input logic [3:0] v,
                             input logic ci, input logic vi, input string tag);
    item_t it;
    addr_i = a;
    #2;
    it.addr = a; it.exp_d = v; it.exp_irq = vi; it.cmp_irq = ci; it.tag = tag;
    sb_q.push_back(it);
    ->sample_ev;
    #1;
  endtask

  task automatic wr_at(input int unsigned md, input int unsigned rem,
                       input logic [1:0] a, input logic [3:0] d, input logic [3:0] ev);
    @(negedge clk);
    while ((cyc % md) != rem) @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1; evt_i = ev;
    @(negedge clk);
    wr_en_i = 1'b0; evt_i = '0;
  endtask

  task automatic pulse_evt(input logic [3:0] ev);
    @(negedge clk);
    evt_i = ev;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6: everything clear after reset.
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      chk_val_now(2'(a), 4'd0, 1'b1, 1'b0, "R6 reset value");
    end
    // R1/R4: tick flags set with enables at 0.
    repeat (12) @(negedge clk);
    chk(2'd2, "R4 tick flag set without enable");
    chk_val_now(2'd2, 4'b0011, 1'b1, 1'b0, "R1 short taps after 16 edges");
    // R2/R8: enable shortest tick.
    wr_at(1, 0, 2'd0, 4'b0001, 4'd0);
    chk_now(2'd0, "R2 tick enable readback");
    chk_now(2'd2, "R8 irq from enabled tick flag");
    // R3/R9
    wr_at(1, 0, 2'd1, 4'b1010, 4'd0);
    chk_now(2'd1, "R3 event enable readback");
    chk_now(2'd0, "R9 other register untouched");
    // R4: disabled event source still sets its flag.
    pulse_evt(4'b0100);
    chk_now(2'd3, "R4 SPI flag without enable");
    pulse_evt(4'b1000);
    chk_now(2'd3, "R8 comparator flag enabled");
    // R5: clear only bit 0 at a quiet phase.
    wr_at(8, 1, 2'd2, 4'b1110, 4'd0);
    chk_now(2'd2, "R5 partial clear");
    addr_i = 2'd2; #2;
    checks++;
    if (rdata_o[0] !== 1'b0) begin
      errors++;
      $display("FAIL R5 bit0 after write 0: got %b expected 0", rdata_o[0]);
    end
    // R5: write 1s leaves flags.
    wr_at(1, 0, 2'd3, 4'b1111, 4'd0);
    chk_now(2'd3, "R5 write one holds");
    chk_val_now(2'd3, 4'b1100, 1'b0, 1'b0, "R5 event flags kept");
    // R7: clear on the edge where tick 0 fires, no longer tap firing.
    wr_at(16, 7, 2'd2, 4'b0000, 4'd0);
    chk_val_now(2'd2, 4'b0001, 1'b1, 1'b1, "R7 tick set beats clear");
    wr_at(1, 0, 2'd3, 4'b0000, 4'b0001);
    chk_val_now(2'd3, 4'b0001, 1'b0, 1'b0, "R7 event set beats clear");
    // R1: longest tap around its rollover.
    wr_at(256, 1, 2'd2, 4'b0000, 4'd0);
    @(negedge clk);
    while ((cyc % 256) != 255) @(negedge clk);
    chk_val_now(2'd2, 4'b0111, 1'b0, 1'b0, "R1 before longest rollover");
    @(negedge clk);
    chk_val_now(2'd2, 4'b1111, 1'b0, 1'b0, "R1 after longest rollover");
    repeat (300) @(negedge clk);
    chk(2'd2, "R1 periodic flags model");
    // R8: disable all, irq falls even with flags set.
    wr_at(1, 0, 2'd0, 4'b0000, 4'd0);
    wr_at(1, 0, 2'd1, 4'b0000, 4'd0);
    chk_val_now(2'd1, 4'b0000, 1'b1, 1'b0, "R8 irq low with enables off");
    chk(2'd3, "R9 event flags final");
    finish_run();
  end
endmodule